// File: doc/BRIEF.md
# IPv4 Header Framing Transmitter

This block turns a parallel description of an IPv4 packet into a byte stream ready for an Ethernet MAC. A parallel header descriptor arrives with a valid/ready handshake. It carries the two MAC addresses and the variable IPv4 fields: DSCP, ECN, total length, identification, flags, fragment offset, TTL, protocol and both addresses. The block then presents an Ethernet header in parallel, with Ethertype 0x0800, on its own valid/ready pair. On an 8-bit AXI4-Stream style output it emits a 20-byte IPv4 header (version 4, IHL 5, no options), followed by the packet payload. The payload is taken from a second 8-bit stream input.

The header checksum is computed in hardware. The block latches the descriptor, spends one cycle folding the nine non-checksum header words into a 16-bit ones'-complement sum, and then serializes the header with the inverted sum placed in bytes 10 and 11.

While the payload passes through, the block counts bytes from the start of the header and compares the count with the declared total length. If the payload ends too early, the final byte is marked with the error sideband and a one-cycle short pulse is raised. If the payload runs past the declared length, the last in-length byte is marked as end of packet, the excess input is consumed and dropped, and a one-cycle overrun pulse is raised. Only one packet is in flight at a time.

The state machine has six states:
- IDLE accepts a descriptor and goes to SUM.
- SUM registers the checksum and goes to HDR.
- HDR hands out the 20 header bytes and goes to PAY once byte 19 is taken.
- PAY forwards payload. A tlast goes to FLUSH. Reaching the declared length with more input to come goes to DRAIN.
- DRAIN discards input up to its tlast and then goes to FLUSH.
- FLUSH waits until both the output stream and the Ethernet header are empty, then returns to IDLE.

Top module: `ipv4_frame_tx`

## Requirements
- R1: While reset is active and after it is released, hdr_rdy_o is 1 and busy_o, tx_vld_o, eth_vld_o and pl_rdy_o are 0.
- R2: After a descriptor is accepted, eth_vld_o rises and eth_dst_o and eth_src_o carry the accepted MAC addresses, while eth_type_o is 0x0800. These outputs hold steady until eth_rdy_i is seen high.
- R3: The first 20 output bytes of each packet are, in this order:
  - 0x45
  - {dscp_i[5:0], ecn_i[1:0]}
  - total length, high byte then low byte
  - identification, high byte then low byte
  - {flags_i[2:0], frag_off_i[12:8]}, then frag_off_i[7:0]
  - ttl_i, then proto_i
  - the two checksum bytes
  - the four bytes of src_ip_i, most significant first
  - the four bytes of dst_ip_i, most significant first
- R4: Output bytes 10 (high) and 11 (low) hold the bitwise inverse of the ones'-complement sum, with end-around carry, of the other nine header words. Each word is formed as {byte 2k, byte 2k+1}. The ones'-complement sum of all ten words of the sent header is 0xFFFF.
- R5: When the payload length equals tot_len_i − 20, every payload byte is forwarded in order after the header. tx_last_o is set only on the final payload byte, and tx_err_o on each byte equals pl_err_i of that byte.
- R6: When the payload stream ends with pl_last_i before the total-length count is reached, its final byte is sent with tx_last_o = 1 and tx_err_o = 1. err_short_o then pulses high for exactly one cycle.
- R7: When the payload keeps going after the count reaches the total length, the byte at that count is sent with tx_last_o = 1. The remaining input, up to and including its pl_last_i, is accepted and not sent. err_long_o pulses for exactly one cycle, and the next packet is unaffected.
- R8: While tx_vld_o is 1 and tx_rdy_i is 0, tx_vld_o stays 1 and tx_data_o, tx_last_o and tx_err_o do not change on the next cycle.
- R9: With random stalls on tx_rdy_i and gaps on pl_vld_i, the output byte sequence is identical to the one without stalls: no byte is lost or repeated.
- R10: After acceptance, hdr_rdy_o stays 0 until the packet's last output byte has been transferred and the Ethernet header has been taken.
- R11: busy_o rises in the cycle after a descriptor is accepted. It stays high while hdr_rdy_o is low and falls when the block returns to IDLE.
- R12: One cycle after acceptance, eth_vld_o is 1 and tx_vld_o is still 0. Two cycles after acceptance, tx_vld_o is 1 with the first header byte. pl_rdy_o is 0 whenever busy_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| hdr_vld_i | input | 1 | Packet descriptor valid |
| hdr_rdy_o | output | 1 | Descriptor accepted when high together with valid |
| dst_mac_i | input | MAC_W | Destination MAC address |
| src_mac_i | input | MAC_W | Source MAC address |
| dscp_i | input | 6 | Differentiated services code point |
| ecn_i | input | 2 | Congestion notification bits |
| tot_len_i | input | 16 | Total length in bytes: header plus payload, at least 21 |
| ident_i | input | 16 | Identification field |
| flags_i | input | 3 | Fragmentation flags |
| frag_off_i | input | 13 | Fragment offset |
| ttl_i | input | 8 | Time to live |
| proto_i | input | 8 | Upper-layer protocol number |
| src_ip_i | input | 32 | Source IPv4 address |
| dst_ip_i | input | 32 | Destination IPv4 address |
| pl_data_i | input | 8 | Payload byte |
| pl_vld_i | input | 1 | Payload byte valid |
| pl_rdy_o | output | 1 | Payload byte taken when high together with valid |
| pl_last_i | input | 1 | Final payload byte of the packet |
| pl_err_i | input | 1 | Error sideband of the payload byte |
| eth_vld_o | output | 1 | Ethernet header valid |
| eth_rdy_i | input | 1 | Ethernet header taken |
| eth_dst_o | output | MAC_W | Destination MAC address out |
| eth_src_o | output | MAC_W | Source MAC address out |
| eth_type_o | output | 16 | Ethertype, always 0x0800 |
| tx_data_o | output | 8 | Output stream byte |
| tx_vld_o | output | 1 | Output byte valid |
| tx_rdy_i | input | 1 | Output byte taken |
| tx_last_o | output | 1 | Final byte of the packet |
| tx_err_o | output | 1 | Error sideband of the output byte |
| busy_o | output | 1 | State machine not idle |
| err_short_o | output | 1 | One-cycle pulse: payload ended before total length |
| err_long_o | output | 1 | One-cycle pulse: payload ran past total length |

## Verification
The timing of each result is fixed relative to the clock edge that accepts the descriptor. busy_o and eth_vld_o are due one edge later. The first header byte is due two edges later, after the checksum cycle and the output register. An error pulse is due one edge after the edge that takes the offending payload byte. Inputs are driven on the falling edge, and the bench decides whether a transfer occurs half a cycle before the rising edge; both handshake readies come from registers, so they cannot change in between. Each transfer is compared in order against a queue built from the requirements, the stall rule is checked on every cycle, and the error pulses are counted per packet once busy_o has fallen.

// File: rtl/ipv4_tx_pkg.sv
package ipv4_tx_pkg;

    localparam int HDR_BYTES = 20;
    localparam int HDR_WORDS = HDR_BYTES / 2;
    localparam int IMG_W     = HDR_BYTES * 8;
    localparam int CSUM_WORD = 5;

    localparam logic [15:0] ETYPE_IPV4 = 16'h0800;
    localparam logic [3:0]  IP_VER     = 4'd4;
    localparam logic [3:0]  IP_IHL     = 4'd5;

    typedef struct packed {
        logic [5:0]  dscp;
        logic [1:0]  ecn;
        logic [15:0] tot_len;
        logic [15:0] ident;
        logic [2:0]  flags;
        logic [12:0] frag_off;
        logic [7:0]  ttl;
        logic [7:0]  proto;
        logic [31:0] src_ip;
        logic [31:0] dst_ip;
    } ip_fields_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SUM,
        ST_HDR,
        ST_PAY,
        ST_DRAIN,
        ST_FLUSH
    } tx_state_t;

    // Header image, first transmitted byte in the top bits.
    function automatic logic [IMG_W-1:0] hdr_image(ip_fields_t f, logic [15:0] csum);
        return {IP_VER, IP_IHL, f.dscp, f.ecn, f.tot_len, f.ident,
                f.flags, f.frag_off, f.ttl, f.proto, csum,
                f.src_ip, f.dst_ip};
    endfunction

    // Ones'-complement addition with the carry wrapped back in.
    function automatic logic [15:0] ones_add(logic [15:0] a, logic [15:0] b);
        logic [16:0] t;
        t = {1'b0, a} + {1'b0, b};
        return t[15:0] + {15'd0, t[16]};
    endfunction

endpackage

// File: rtl/ipv4_hdr_csum.sv
module ipv4_hdr_csum
    import ipv4_tx_pkg::*;
(
    input  ip_fields_t  fields_i,
    output logic [15:0] csum_o
);

    logic [IMG_W-1:0] img;
    logic [15:0]      words [HDR_WORDS];
    logic [15:0]      acc;

    assign img = hdr_image(fields_i, 16'h0000);

    for (genvar g = 0; g < HDR_WORDS; g++) begin : g_word
        assign words[g] = img[IMG_W-1-16*g -: 16];
    end

    always_comb begin
        acc = 16'h0000;
        for (int i = 0; i < HDR_WORDS; i++) begin
            acc = ones_add(acc, words[i]);
        end
        csum_o = ~acc;
    end

endmodule

// File: rtl/ipv4_hdr_bytes.sv
module ipv4_hdr_bytes
    import ipv4_tx_pkg::*;
#(
    parameter int IDX_W = $clog2(HDR_BYTES)
) (
    input  ip_fields_t       fields_i,
    input  logic [15:0]      csum_i,
    input  logic [IDX_W-1:0] idx_i,
    output logic [7:0]       byte_o
);

    logic [IMG_W-1:0] img;
    logic [7:0]       bytes [HDR_BYTES];

    assign img = hdr_image(fields_i, csum_i);

    for (genvar g = 0; g < HDR_BYTES; g++) begin : g_byte
        assign bytes[g] = img[IMG_W-1-8*g -: 8];
    end

    always_comb begin
        if (int'(idx_i) < HDR_BYTES) begin
            byte_o = bytes[idx_i];
        end else begin
            byte_o = 8'h00;
        end
    end

endmodule

// File: rtl/ipv4_tx_skid.sv
module ipv4_tx_skid #(
    parameter int W = 10
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] in_data,
    input  logic         in_vld,
    output logic         in_rdy,
    output logic [W-1:0] out_data,
    output logic         out_vld,
    input  logic         out_rdy
);

    logic [W-1:0] main_q, side_q;
    logic         main_vld_q, side_vld_q;
    logic         in_fire, out_fire;

    assign in_rdy   = !side_vld_q;
    assign in_fire  = in_vld && in_rdy;
    assign out_fire = main_vld_q && out_rdy;
    assign out_data = main_q;
    assign out_vld  = main_vld_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            main_q     <= '0;
            side_q     <= '0;
            main_vld_q <= 1'b0;
            side_vld_q <= 1'b0;
        end else if (out_fire || !main_vld_q) begin
            if (side_vld_q) begin
                main_q     <= side_q;
                main_vld_q <= 1'b1;
                side_vld_q <= 1'b0;
            end else if (in_fire) begin
                main_q     <= in_data;
                main_vld_q <= 1'b1;
            end else begin
                main_vld_q <= 1'b0;
            end
        end else if (in_fire) begin
            side_q     <= in_data;
            side_vld_q <= 1'b1;
        end
    end

endmodule

// File: rtl/ipv4_frame_tx.sv
module ipv4_frame_tx
    import ipv4_tx_pkg::*;
#(
    parameter int MAC_W = 48
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hdr_vld_i,
    output logic             hdr_rdy_o,
    input  logic [MAC_W-1:0] dst_mac_i,
    input  logic [MAC_W-1:0] src_mac_i,
    input  logic [5:0]       dscp_i,
    input  logic [1:0]       ecn_i,
    input  logic [15:0]      tot_len_i,
    input  logic [15:0]      ident_i,
    input  logic [2:0]       flags_i,
    input  logic [12:0]      frag_off_i,
    input  logic [7:0]       ttl_i,
    input  logic [7:0]       proto_i,
    input  logic [31:0]      src_ip_i,
    input  logic [31:0]      dst_ip_i,
    input  logic [7:0]       pl_data_i,
    input  logic             pl_vld_i,
    output logic             pl_rdy_o,
    input  logic             pl_last_i,
    input  logic             pl_err_i,
    output logic             eth_vld_o,
    input  logic             eth_rdy_i,
    output logic [MAC_W-1:0] eth_dst_o,
    output logic [MAC_W-1:0] eth_src_o,
    output logic [15:0]      eth_type_o,
    output logic [7:0]       tx_data_o,
    output logic             tx_vld_o,
    input  logic             tx_rdy_i,
    output logic             tx_last_o,
    output logic             tx_err_o,
    output logic             busy_o,
    output logic             err_short_o,
    output logic             err_long_o
);

    localparam int          IDX_W    = $clog2(HDR_BYTES);
    localparam int          OUT_W    = 10;
    localparam logic [15:0] LAST_HDR = 16'(HDR_BYTES - 1);

    tx_state_t        state_q, state_d;
    ip_fields_t       fld_q, fld_in;
    logic [15:0]      csum_q, csum_w, pos_q, pos_inc;
    logic [7:0]       hdr_byte;
    logic             eth_vld_q;
    logic [MAC_W-1:0] eth_dst_q, eth_src_q;
    logic             err_short_q, err_short_d, err_long_q, err_long_d;
    logic             accept, pay_fire, len_hit, short_end, pos_step;

    logic             int_vld, int_rdy, int_last, int_err, pl_rdy_c;
    logic [7:0]       int_data;
    logic [OUT_W-1:0] skid_out;

    assign fld_in = '{dscp: dscp_i, ecn: ecn_i, tot_len: tot_len_i,
                      ident: ident_i, flags: flags_i, frag_off: frag_off_i,
                      ttl: ttl_i, proto: proto_i, src_ip: src_ip_i,
                      dst_ip: dst_ip_i};

    assign hdr_rdy_o = (state_q == ST_IDLE);
    assign busy_o    = (state_q != ST_IDLE);
    assign accept    = hdr_vld_i && (state_q == ST_IDLE);
    assign pos_inc   = pos_q + 16'd1;
    assign len_hit   = (pos_inc >= fld_q.tot_len);
    assign short_end = (pos_inc < fld_q.tot_len);
    assign pay_fire  = (state_q == ST_PAY) && pl_vld_i && int_rdy;
    assign pos_step  = ((state_q == ST_HDR) && int_rdy) || pay_fire;

    ipv4_hdr_csum u_csum (
        .fields_i (fld_q),
        .csum_o   (csum_w)
    );

    ipv4_hdr_bytes #(.IDX_W(IDX_W)) u_bytes (
        .fields_i (fld_q),
        .csum_i   (csum_q),
        .idx_i    (pos_q[IDX_W-1:0]),
        .byte_o   (hdr_byte)
    );

    ipv4_tx_skid #(.W(OUT_W)) u_skid (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_data  ({int_err, int_last, int_data}),
        .in_vld   (int_vld),
        .in_rdy   (int_rdy),
        .out_data (skid_out),
        .out_vld  (tx_vld_o),
        .out_rdy  (tx_rdy_i)
    );

    assign tx_err_o  = skid_out[9];
    assign tx_last_o = skid_out[8];
    assign tx_data_o = skid_out[7:0];

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state and stream outputs.
    always_comb begin
        state_d     = state_q;
        int_vld     = 1'b0;
        int_data    = 8'h00;
        int_last    = 1'b0;
        int_err     = 1'b0;
        pl_rdy_c    = 1'b0;
        err_short_d = 1'b0;
        err_long_d  = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (hdr_vld_i) state_d = ST_SUM;
            end
            ST_SUM: begin
                state_d = ST_HDR;
            end
            ST_HDR: begin
                int_vld  = 1'b1;
                int_data = hdr_byte;
                if (int_rdy && pos_q == LAST_HDR) state_d = ST_PAY;
            end
            ST_PAY: begin
                pl_rdy_c = int_rdy;
                int_vld  = pl_vld_i;
                int_data = pl_data_i;
                int_last = pl_last_i;
                int_err  = pl_err_i;
                if (pay_fire) begin
                    if (pl_last_i) begin
                        if (short_end) begin
                            int_err     = 1'b1;
                            err_short_d = 1'b1;
                        end
                        state_d = ST_FLUSH;
                    end else if (len_hit) begin
                        int_last   = 1'b1;
                        err_long_d = 1'b1;
                        state_d    = ST_DRAIN;
                    end
                end
            end
            ST_DRAIN: begin
                pl_rdy_c = 1'b1;
                if (pl_vld_i && pl_last_i) state_d = ST_FLUSH;
            end
            ST_FLUSH: begin
                if (!tx_vld_o && !eth_vld_q) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    assign pl_rdy_o = pl_rdy_c;

    // Datapath registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fld_q       <= '0;
            csum_q      <= '0;
            pos_q       <= '0;
            eth_vld_q   <= 1'b0;
            eth_dst_q   <= '0;
            eth_src_q   <= '0;
            err_short_q <= 1'b0;
            err_long_q  <= 1'b0;
        end else begin
            err_short_q <= err_short_d;
            err_long_q  <= err_long_d;
            if (accept) begin
                fld_q     <= fld_in;
                eth_dst_q <= dst_mac_i;
                eth_src_q <= src_mac_i;
                eth_vld_q <= 1'b1;
                pos_q     <= '0;
            end else begin
                if (eth_vld_q && eth_rdy_i) eth_vld_q <= 1'b0;
                if (pos_step) pos_q <= pos_inc;
            end
            if (state_q == ST_SUM) csum_q <= csum_w;
        end
    end

    assign eth_vld_o   = eth_vld_q;
    assign eth_dst_o   = eth_dst_q;
    assign eth_src_o   = eth_src_q;
    assign eth_type_o  = ETYPE_IPV4;
    assign err_short_o = err_short_q;
    assign err_long_o  = err_long_q;

endmodule

// File: rtl/ipv4_frame_tx_chk.sv
module ipv4_frame_tx_chk #(
    parameter int MAC_W = 48
) (
    input logic             clk,
    input logic             rst_n,
    input logic             hdr_vld_i,
    input logic             hdr_rdy_o,
    input logic             pl_rdy_o,
    input logic             eth_vld_o,
    input logic             eth_rdy_i,
    input logic [MAC_W-1:0] eth_dst_o,
    input logic [MAC_W-1:0] eth_src_o,
    input logic [7:0]       tx_data_o,
    input logic             tx_vld_o,
    input logic             tx_rdy_i,
    input logic             tx_last_o,
    input logic             tx_err_o,
    input logic             busy_o,
    input logic             err_short_o,
    input logic             err_long_o
);

    a_r8_tx_hold: assert property (@(posedge clk) disable iff (!rst_n)
        tx_vld_o && !tx_rdy_i |=> tx_vld_o && $stable(tx_data_o)
                                  && $stable(tx_last_o) && $stable(tx_err_o));

    a_r2_eth_hold: assert property (@(posedge clk) disable iff (!rst_n)
        eth_vld_o && !eth_rdy_i |=> eth_vld_o && $stable(eth_dst_o)
                                    && $stable(eth_src_o));

    a_r10_one_in_flight: assert property (@(posedge clk) disable iff (!rst_n)
        hdr_vld_i && hdr_rdy_o |=> !hdr_rdy_o && busy_o);

    a_r11_busy_start: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> $past(hdr_vld_i && hdr_rdy_o));

    a_r6_short_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        err_short_o |=> !err_short_o);

    a_r7_long_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        err_long_o |=> !err_long_o);

    a_r12_idle_no_payload: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> !pl_rdy_o);

endmodule

bind ipv4_frame_tx ipv4_frame_tx_chk #(.MAC_W(MAC_W)) u_chk (.*);

// File: tb/ipv4_frame_tx_bench.sv
`timescale 1ns / 1ps
module ipv4_frame_tx_bench;

    localparam int MAC_W = 48;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic             hdr_vld_i = 1'b0;
    logic             hdr_rdy_o;
    logic [MAC_W-1:0] dst_mac_i = '0, src_mac_i = '0;
    logic [5:0]       dscp_i = '0;
    logic [1:0]       ecn_i = '0;
    logic [15:0]      tot_len_i = '0, ident_i = '0;
    logic [2:0]       flags_i = '0;
    logic [12:0]      frag_off_i = '0;
    logic [7:0]       ttl_i = '0, proto_i = '0;
    logic [31:0]      src_ip_i = '0, dst_ip_i = '0;
    logic [7:0]       pl_data_i = '0;
    logic             pl_vld_i = 1'b0, pl_last_i = 1'b0, pl_err_i = 1'b0;
    logic             pl_rdy_o;
    logic             eth_vld_o;
    logic             eth_rdy_i = 1'b0;
    logic [MAC_W-1:0] eth_dst_o, eth_src_o;
    logic [15:0]      eth_type_o;
    logic [7:0]       tx_data_o;
    logic             tx_vld_o, tx_last_o, tx_err_o;
    logic             tx_rdy_i = 1'b1;
    logic             busy_o, err_short_o, err_long_o;

    ipv4_frame_tx #(.MAC_W(MAC_W)) u_ipv4_frame_tx (.*);

    int checks = 0;
    int fails  = 0;
    int short_cnt = 0, long_cnt = 0;
    int cyc = 0;
    logic [9:0] exp_q [$];
    logic [7:0] pay_mem [64];
    logic [7:0] rx_hdr [20];

    task automatic chk(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    // Watchdog.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            fails++;
            $display("FAIL R9 watchdog expired: actual %0d cycles expected fewer", cyc);
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    // Per-cycle monitor: stall stability (R8) and error pulse counting.
    logic       pv = 1'b0, pr = 1'b0, pl = 1'b0, pe = 1'b0;
    logic [7:0] pd = '0;
    always begin
        @(negedge clk);
        #2;
        if (rst_n) begin
            if (pv && !pr) begin
                chk(tx_vld_o && tx_data_o == pd && tx_last_o == pl && tx_err_o == pe,
                    "R8", "stalled output changed",
                    {tx_vld_o, tx_err_o, tx_last_o, tx_data_o},
                    {1'b1, pe, pl, pd});
            end
            if (err_short_o) short_cnt++;
            if (err_long_o) long_cnt++;
        end
        pv = tx_vld_o; pr = tx_rdy_i; pd = tx_data_o; pl = tx_last_o; pe = tx_err_o;
    end

    task automatic build_expected(input int n, input int decl, input bit lerr);
        logic [7:0]  hb [20];
        int unsigned s;
        int          outn;
        logic [15:0] tl;
        tl     = 16'(20 + decl);
        hb[0]  = 8'h45;
        hb[1]  = {dscp_i, ecn_i};
        hb[2]  = tl[15:8];       hb[3]  = tl[7:0];
        hb[4]  = ident_i[15:8];  hb[5]  = ident_i[7:0];
        hb[6]  = {flags_i, frag_off_i[12:8]};
        hb[7]  = frag_off_i[7:0];
        hb[8]  = ttl_i;          hb[9]  = proto_i;
        hb[10] = 8'h00;          hb[11] = 8'h00;
        for (int k = 0; k < 4; k++) hb[12+k] = src_ip_i[31-8*k -: 8];
        for (int k = 0; k < 4; k++) hb[16+k] = dst_ip_i[31-8*k -: 8];
        s = 0;
        for (int k = 0; k < 10; k++) s += {16'd0, hb[2*k], hb[2*k+1]};
        while (s > 32'hFFFF) s = (s & 32'hFFFF) + (s >> 16);
        hb[10] = ~s[15:8];
        hb[11] = ~s[7:0];
        exp_q.delete();
        for (int k = 0; k < 20; k++) exp_q.push_back({2'b00, hb[k]});
        outn = (n < decl) ? n : decl;
        for (int k = 0; k < outn; k++) begin
            logic lst, er;
            lst = (k == outn - 1);
            er  = (n < decl) ? lst : (lerr && k == n - 1);
            exp_q.push_back({er, lst, pay_mem[k]});
        end
    endtask

    task automatic drive_hdr(input int decl);
        @(negedge clk);
        tot_len_i = 16'(20 + decl);
        hdr_vld_i = 1'b1;
        #1;
        while (!hdr_rdy_o) begin
            @(negedge clk);
            #1;
        end
        @(negedge clk);
        hdr_vld_i = 1'b0;
        #1;
        chk(busy_o && eth_vld_o && !hdr_rdy_o, "R11", "busy/eth one edge after accept",
            {busy_o, eth_vld_o, hdr_rdy_o}, 3'b110);
        chk(!tx_vld_o, "R12", "no output one edge after accept", tx_vld_o, 0);
        @(negedge clk);
        @(negedge clk);
        #1;
        chk(tx_vld_o && tx_data_o == 8'h45, "R12", "first header byte after two edges",
            {tx_vld_o, tx_data_o}, {1'b1, 8'h45});
    endtask

    task automatic drive_pay(input int n, input bit bp, input bit lerr);
        int i = 0;
        while (i < n) begin
            @(negedge clk);
            if (bp && $urandom_range(0, 3) == 0) begin
                pl_vld_i = 1'b0;
            end else begin
                pl_vld_i  = 1'b1;
                pl_data_i = pay_mem[i];
                pl_last_i = (i == n - 1);
                pl_err_i  = lerr && (i == n - 1);
            end
            #1;
            if (pl_vld_i && pl_rdy_o) i++;
        end
        @(negedge clk);
        pl_vld_i  = 1'b0;
        pl_last_i = 1'b0;
        pl_err_i  = 1'b0;
    endtask

    task automatic sink(input bit bp, input string tag);
        int  k = 0;
        bit  done = 0;
        while (!done) begin
            @(negedge clk);
            tx_rdy_i = bp ? ($urandom_range(0, 2) != 0) : 1'b1;
            #1;
            if (tx_vld_o && tx_rdy_i) begin
                logic [9:0] e;
                string      t;
                if (exp_q.size() == 0) begin
                    chk(0, tag, "unexpected extra byte", tx_data_o, 0);
                    done = 1;
                end else begin
                    e = exp_q.pop_front();
                    t = (k == 10 || k == 11) ? "R4" : (k < 20 ? "R3" : tag);
                    chk({tx_err_o, tx_last_o, tx_data_o} == e, t,
                        $sformatf("byte %0d {err,last,data}", k),
                        {tx_err_o, tx_last_o, tx_data_o}, e);
                    if (k < 20) rx_hdr[k] = tx_data_o;
                    if (tx_last_o) done = 1;
                end
                k++;
            end
        end
        @(negedge clk);
        tx_rdy_i = 1'b1;
    endtask

    task automatic eth_sink(input int dly);
        logic [MAC_W-1:0] d0, s0;
        @(negedge clk);
        eth_rdy_i = 1'b0;
        #1;
        while (!eth_vld_o) begin
            @(negedge clk);
            #1;
        end
        chk(eth_dst_o == dst_mac_i && eth_src_o == src_mac_i && eth_type_o == 16'h0800,
            "R2", "ethernet header fields", {eth_type_o, eth_dst_o[15:0]},
            {16'h0800, dst_mac_i[15:0]});
        d0 = eth_dst_o;
        s0 = eth_src_o;
        for (int j = 0; j < dly; j++) begin
            @(negedge clk);
            #1;
            if (j == dly - 1) begin
                chk(eth_vld_o && eth_dst_o == d0 && eth_src_o == s0, "R2",
                    "ethernet header held", eth_vld_o, 1);
                chk(!hdr_rdy_o && busy_o, "R10", "ready low while ethernet header pending",
                    {hdr_rdy_o, busy_o}, 2'b01);
            end
        end
        @(negedge clk);
        eth_rdy_i = 1'b1;
        @(negedge clk);
        eth_rdy_i = 1'b0;
    endtask

    task automatic run_frame(input int n, input int decl, input bit bp, input int dly,
                             input bit lerr, input string tag, input int seed);
        int unsigned s;
        int          t = 0;
        for (int k = 0; k < 64; k++) pay_mem[k] = 8'(k * 37 + seed * 11 + 5);
        build_expected(n, decl, lerr);
        short_cnt = 0;
        long_cnt  = 0;
        fork
            drive_hdr(decl);
            drive_pay(n, bp, lerr);
            sink(bp, tag);
            eth_sink(dly);
        join
        while (busy_o && t < 50) begin
            @(negedge clk);
            #1;
            t++;
        end
        chk(!busy_o && hdr_rdy_o, "R11", "idle again after packet", {busy_o, hdr_rdy_o}, 2'b01);
        chk(exp_q.size() == 0, tag, "bytes missing", exp_q.size(), 0);
        chk(short_cnt == ((n < decl) ? 1 : 0), "R6", "short pulse count", short_cnt,
            (n < decl) ? 1 : 0);
        chk(long_cnt == ((n > decl) ? 1 : 0), "R7", "overrun pulse count", long_cnt,
            (n > decl) ? 1 : 0);
        s = 0;
        for (int k = 0; k < 10; k++) s += {16'd0, rx_hdr[2*k], rx_hdr[2*k+1]};
        while (s > 32'hFFFF) s = (s & 32'hFFFF) + (s >> 16);
        chk(s == 32'hFFFF, "R4", "sum of sent header", s, 32'hFFFF);
    endtask

    task automatic set_fields(input logic [7:0] b);
        dst_mac_i  = {6{b ^ 8'h5A}};
        src_mac_i  = {6{b ^ 8'hC3}};
        dscp_i     = b[5:0];
        ecn_i      = b[7:6];
        ident_i    = {b, ~b};
        flags_i    = 3'b010;
        frag_off_i = {5'h00, b};
        ttl_i      = 8'd64;
        proto_i    = 8'd17;
        src_ip_i   = {8'd10, b, 8'd1, 8'd2};
        dst_ip_i   = {8'd192, 8'd168, b, 8'd9};
    endtask

    initial begin
        repeat (4) @(negedge clk);
        #1;
        chk(hdr_rdy_o && !busy_o && !tx_vld_o && !eth_vld_o && !pl_rdy_o, "R1",
            "state during reset", {hdr_rdy_o, busy_o, tx_vld_o, eth_vld_o, pl_rdy_o}, 5'b10000);
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        chk(hdr_rdy_o && !busy_o && !tx_vld_o && !eth_vld_o && !pl_rdy_o, "R1",
            "state after reset", {hdr_rdy_o, busy_o, tx_vld_o, eth_vld_o, pl_rdy_o}, 5'b10000);

        set_fields(8'h21);
        run_frame(4, 4, 0, 0, 0, "R5", 1);       // exact length, no stalls
        set_fields(8'h7E);
        run_frame(30, 30, 1, 2, 0, "R9", 2);     // stalls and gaps
        set_fields(8'h03);
        run_frame(6, 10, 0, 0, 0, "R6", 3);      // payload ends early
        set_fields(8'hB4);
        run_frame(6, 10, 1, 1, 0, "R6", 4);      // early end under stalls
        set_fields(8'h48);
        run_frame(9, 5, 0, 0, 0, "R7", 5);       // overrun, excess dropped
        set_fields(8'h49);
        run_frame(7, 7, 0, 0, 1, "R7", 6);       // next packet after overrun, err sideband
        set_fields(8'h90);
        run_frame(20, 12, 1, 0, 0, "R7", 7);     // overrun under stalls
        set_fields(8'hFF);
        tot_len_i = 16'hFFFF;
        run_frame(1, 1, 0, 40, 0, "R10", 8);     // ethernet header held long, one byte
        set_fields(8'h00);
        run_frame(3, 3, 0, 0, 1, "R5", 9);       // all-zero fields, error sideband passes
        set_fields(8'hFF);
        ident_i  = 16'hFFFF;
        src_ip_i = 32'hFFFF_FFFF;
        dst_ip_i = 32'hFFFF_FFFF;
        run_frame(12, 12, 1, 3, 0, "R9", 10);    // heavy carries in checksum

        repeat (5) @(negedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule